// File: doc/BRIEF.md
# Redundant Command Channel Voter

This block turns the command words produced by several parallel optical receive lanes into one trusted command. Eight primary lanes each feed a slot of the voter. Four spare lanes stand by: when a primary lane dies, a per-slot steering field swaps that slot's input over to one of the spares. A single spare may back up more than one slot. After steering, each enabled slot delivers one command word. A bitwise majority vote over the enabled slots then produces the executed command, together with a valid strobe and a flag that shows whether any enabled slot disagreed with the result.

A slot can be disabled altogether. This leaves it out of both the vote and the arrival check, so the control path stays usable with as few as two live lanes, or even one. The steering and enable settings are loaded together through a single write strobe. Each vote waits until every enabled slot has delivered a word within a bounded arrival window. If the window runs out first, the partial set is thrown away and a timeout pulse is raised. With exactly two enabled slots there is no majority when they differ, so the block then issues nothing and reports a pair mismatch. The primary slot count is a parameter meant to range from three to eleven.

Top module: `cmd_vote_hub`

## Requirements
- R1: While reset is low and on the first cycle after it, `cmd_vld`, `cmd_disagree`, `cmd_mismatch` and `cmd_timeout` are 0. Reset also restores the configuration: every slot takes its own primary lane and every slot is enabled.
- R2: A high `cfg_wr` loads `cfg_steer` and `cfg_en` at the clock edge. For slot s, the field `cfg_steer[3s+2:3s]` picks the slot's source: values 0 to 3 select primary lane s, and values 4 to 7 select spare lane 0 to 3, which is lane number 8 to 11 of `lane_data`/`lane_vld` (lane k uses bits `lane_data[8k+7:8k]`). One spare may feed several slots.
- R3: When a slot is steered to a spare, the valid strobe and data of its own primary lane have no effect.
- R4: Each bit of `cmd_word` is 1 only when strictly more than half of the enabled slots carry a 1 in that bit. A tie gives 0.
- R5: A slot whose `cfg_en` bit is 0 takes no part in the vote. Its valid strobe neither opens an arrival window nor completes one.
- R6: `cmd_disagree` is high together with `cmd_vld`, and only when at least one enabled slot's word differs from the issued `cmd_word`.
- R7: With exactly two enabled slots whose words differ, `cmd_vld` stays 0 and `cmd_mismatch` pulses for one cycle. If the two words agree, the command is issued normally.
- R8: The first valid word from an enabled slot opens an arrival window. If every enabled slot has delivered a word within 8 consecutive clock edges, counting the opening edge, then `cmd_vld` is high for exactly one cycle, registered at the edge that samples the last missing valid.
- R9: If the window's 8th edge passes without every enabled slot having delivered, `cmd_timeout` pulses for one cycle, registered at that 8th edge. All words collected so far are discarded and the next valid opens a new window.
- R10: Within a window, a slot keeps the first word it delivers. Later valid strobes from that slot are ignored until the window closes.
- R11: With a single enabled slot, its word is issued as `cmd_word` and `cmd_disagree` is 0.
- R12: At most one of `cmd_vld`, `cmd_mismatch` and `cmd_timeout` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| lane_data | input | 96 | Command words of lanes 0..11, 8 bits each; lanes 8..11 are spares |
| lane_vld | input | 12 | Per-lane word valid strobe |
| cfg_wr | input | 1 | Load strobe for steering and enable settings |
| cfg_steer | input | 24 | 3-bit steering field per primary slot |
| cfg_en | input | 8 | Per-slot vote enable |
| cmd_vld | output | 1 | One-cycle strobe: command issued |
| cmd_word | output | 8 | Voted command word, held between strobes |
| cmd_disagree | output | 1 | Issued command was not unanimous |
| cmd_mismatch | output | 1 | Two enabled slots conflicted, nothing issued |
| cmd_timeout | output | 1 | Arrival window expired |

## Verification
The two functions that can fall in the same cycle are closing a window and issuing its vote. A late valid on the 8th edge of a window both completes the arrival set and meets the expiry point, so the bench staggers arrivals one slot per cycle and delivers the last one exactly on the 8th edge. There it expects a command rather than a timeout. It also checks that a repeated strobe from an early slot inside that window does not replace that slot's first word. A second pairing occurs in the two-slot case, where completion and conflict detection coincide. The bench judges it by requiring a mismatch pulse with no command strobe. Random rounds with arbitrary steering and enable masks are compared against a bench-side model of steering and strict-majority voting.

// File: rtl/cvh_pkg.sv
// Shared constants for the redundant command voter.
// Assumes a fixed pool of four spare lanes addressed by a 3-bit steering field.
package cvh_pkg;
    localparam int STEER_W     = 3;
    localparam int SPARE_LANES = 4;
endpackage

// File: rtl/cvh_lane_steer.sv
// Per-slot input selection: each primary slot takes either its own lane or
// one of the spare lanes, as its steering field says.
// Assumes steering field bit 2 set means "spare", bits 1:0 pick the spare.
module cvh_lane_steer
    import cvh_pkg::*;
#(
    parameter int NP = 8,
    parameter int W  = 8
) (
    input  logic [(NP+SPARE_LANES)*W-1:0] lane_data,
    input  logic [NP+SPARE_LANES-1:0]     lane_vld,
    input  logic [NP*STEER_W-1:0]         steer,
    output logic [NP*W-1:0]               slot_data,
    output logic [NP-1:0]                 slot_vld
);
    logic [W-1:0]           spare_w [SPARE_LANES];
    logic [SPARE_LANES-1:0] spare_v;

    generate
        for (genvar k = 0; k < SPARE_LANES; k++) begin : g_spare
            // Unpack spare lane k for indexed selection.
            assign spare_w[k] = lane_data[(NP+k)*W +: W];
            assign spare_v[k] = lane_vld[NP+k];
        end

        for (genvar s = 0; s < NP; s++) begin : g_slot
            logic [STEER_W-1:0] fld;
            assign fld = steer[s*STEER_W +: STEER_W];
            // Word routed into slot s.
            assign slot_data[s*W +: W] = fld[2] ? spare_w[fld[1:0]] : lane_data[s*W +: W];
            // Valid routed into slot s; the own lane is ignored when a spare is chosen.
            assign slot_vld[s] = fld[2] ? spare_v[fld[1:0]] : lane_vld[s];
        end
    endgenerate
endmodule

// File: rtl/cvh_vote_window.sv
// Arrival collector: latches the first word of each enabled slot, opens a
// window on the first arrival and reports completion (combinational) or
// expiry (registered pulse) after WIN edges.
// Assumes WIN >= 2 and that the enable mask is stable during a window.
module cvh_vote_window #(
    parameter int NP  = 8,
    parameter int W   = 8,
    parameter int WIN = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NP*W-1:0] slot_data,
    input  logic [NP-1:0]   slot_vld,
    input  logic [NP-1:0]   en,
    output logic            fire,
    output logic [NP*W-1:0] word_set,
    output logic            timeout
);
    localparam int CNTW = $clog2(WIN + 1);

    logic            busy_q;
    logic [CNTW-1:0] cnt_q;
    logic [NP-1:0]   cap_q;
    logic [NP*W-1:0] word_q;
    logic [NP-1:0]   take;
    logic [NP-1:0]   cap_nx;

    // New first-in-window arrivals from enabled slots.
    assign take   = slot_vld & en & ~cap_q;
    assign cap_nx = cap_q | take;
    // Complete when this edge brings the last missing enabled slot.
    assign fire   = (|take) && ((cap_nx & en) == en);

    generate
        for (genvar s = 0; s < NP; s++) begin : g_word
            // Keep the first word of the window, else accept the arriving one.
            assign word_set[s*W +: W] = take[s] ? slot_data[s*W +: W] : word_q[s*W +: W];
        end
    endgenerate

    // Window state, collected words and the expiry pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q  <= 1'b0;
            cnt_q   <= '0;
            cap_q   <= '0;
            word_q  <= '0;
            timeout <= 1'b0;
        end else begin
            timeout <= 1'b0;
            word_q  <= word_set;
            if (fire) begin
                busy_q <= 1'b0;
                cnt_q  <= '0;
                cap_q  <= '0;
            end else if (busy_q && cnt_q == CNTW'(WIN - 1)) begin
                timeout <= 1'b1;
                busy_q  <= 1'b0;
                cnt_q   <= '0;
                cap_q   <= '0;
            end else if (busy_q) begin
                cnt_q <= cnt_q + CNTW'(1);
                cap_q <= cap_nx;
            end else if (|take) begin
                busy_q <= 1'b1;
                cnt_q  <= CNTW'(1);
                cap_q  <= cap_nx;
            end
        end
    end

    AST_WINDOW_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |-> (cnt_q != '0 && cnt_q < CNTW'(WIN)));  // R8
    AST_TIMEOUT_FROM_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        timeout |-> $past(busy_q));  // R9
    AST_TIMEOUT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        timeout |=> !timeout);  // R9
endmodule

// File: rtl/cvh_bit_majority.sv
// Bitwise strict-majority vote over the enabled slots, plus a flag when any
// enabled word differs from the result and a flag for the two-slot case.
// Purely combinational; assumes NP < 2**CW.
module cvh_bit_majority #(
    parameter int NP = 8,
    parameter int W  = 8
) (
    input  logic [NP*W-1:0] words,
    input  logic [NP-1:0]   en,
    output logic [W-1:0]    maj,
    output logic            any_diff,
    output logic            pair_only
);
    localparam int CW = $clog2(NP + 1);

    logic [CW-1:0] en_cnt;

    // Number of enabled slots.
    always_comb begin
        en_cnt = '0;
        for (int s = 0; s < NP; s++)
            if (en[s]) en_cnt = en_cnt + CW'(1);
    end

    generate
        for (genvar b = 0; b < W; b++) begin : g_bit
            logic [CW-1:0] ones;
            // Ones in bit b among enabled slots.
            always_comb begin
                ones = '0;
                for (int s = 0; s < NP; s++)
                    if (en[s] && words[s*W+b]) ones = ones + CW'(1);
            end
            // Strict majority: twice the ones exceeds the enabled count.
            assign maj[b] = {ones, 1'b0} > {1'b0, en_cnt};
        end
    endgenerate

    // Any enabled slot off the voted word.
    always_comb begin
        any_diff = 1'b0;
        for (int s = 0; s < NP; s++)
            if (en[s] && words[s*W +: W] != maj) any_diff = 1'b1;
    end

    assign pair_only = (en_cnt == CW'(2));
endmodule

// File: rtl/cmd_vote_hub.sv
// Redundant command voter top: holds steering/enable settings, steers spare
// lanes into failed slots, collects one word per enabled slot and issues the
// bitwise-majority command with disagree, pair-mismatch and timeout flags.
// Assumes 3 <= NP <= 11 primary slots and four spare lanes.
module cmd_vote_hub
    import cvh_pkg::*;
#(
    parameter int NP  = 8,
    parameter int W   = 8,
    parameter int WIN = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [(NP+SPARE_LANES)*W-1:0] lane_data,
    input  logic [NP+SPARE_LANES-1:0]     lane_vld,
    input  logic                          cfg_wr,
    input  logic [NP*STEER_W-1:0]         cfg_steer,
    input  logic [NP-1:0]                 cfg_en,
    output logic                          cmd_vld,
    output logic [W-1:0]                  cmd_word,
    output logic                          cmd_disagree,
    output logic                          cmd_mismatch,
    output logic                          cmd_timeout
);
    logic [NP*STEER_W-1:0] steer_q;
    logic [NP-1:0]         en_q;
    logic [NP*W-1:0]       slot_data;
    logic [NP-1:0]         slot_vld;
    logic                  fire;
    logic [NP*W-1:0]       word_set;
    logic [W-1:0]          maj;
    logic                  any_diff;
    logic                  pair_only;
    logic                  pair_conflict;

    // Configuration registers: own lane, all enabled after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            steer_q <= '0;
            en_q    <= '1;
        end else if (cfg_wr) begin
            steer_q <= cfg_steer;
            en_q    <= cfg_en;
        end
    end

    cvh_lane_steer #(.NP(NP), .W(W)) u_steer (
        .lane_data (lane_data),
        .lane_vld  (lane_vld),
        .steer     (steer_q),
        .slot_data (slot_data),
        .slot_vld  (slot_vld)
    );

    cvh_vote_window #(.NP(NP), .W(W), .WIN(WIN)) u_window (
        .clk      (clk),
        .rst_n    (rst_n),
        .slot_data(slot_data),
        .slot_vld (slot_vld),
        .en       (en_q),
        .fire     (fire),
        .word_set (word_set),
        .timeout  (cmd_timeout)
    );

    cvh_bit_majority #(.NP(NP), .W(W)) u_vote (
        .words    (word_set),
        .en       (en_q),
        .maj      (maj),
        .any_diff (any_diff),
        .pair_only(pair_only)
    );

    // Two enabled slots that differ give no majority.
    assign pair_conflict = pair_only && any_diff;

    // Result registers: one-cycle strobes, held command word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_vld      <= 1'b0;
            cmd_word     <= '0;
            cmd_disagree <= 1'b0;
            cmd_mismatch <= 1'b0;
        end else begin
            cmd_vld      <= fire && !pair_conflict;
            cmd_disagree <= fire && !pair_conflict && any_diff;
            cmd_mismatch <= fire && pair_conflict;
            if (fire && !pair_conflict) cmd_word <= maj;
        end
    end

    AST_ONE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cmd_vld, cmd_mismatch, cmd_timeout}));  // R12
    AST_DISAGREE_WITH_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_disagree |-> cmd_vld);  // R6
    AST_CMD_NEEDS_ARRIVAL: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_vld |-> $past(|lane_vld));  // R8
    AST_MISMATCH_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_mismatch |-> ($past($countones(en_q)) == 2));  // R7
endmodule

// File: tb/cmd_vote_hub_test.sv
module cmd_vote_hub_test;
    localparam int CLK_P = 10;
    localparam int NP = 8;
    localparam int NS = 4;
    localparam int NL = NP + NS;
    localparam int W  = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NL*W-1:0]   lane_data = '0;
    logic [NL-1:0]     lane_vld = '0;
    logic              cfg_wr = 1'b0;
    logic [NP*3-1:0]   cfg_steer = '0;
    logic [NP-1:0]     cfg_en = '1;
    logic              cmd_vld, cmd_disagree, cmd_mismatch, cmd_timeout;
    logic [W-1:0]      cmd_word;

    int n_chk = 0;
    int n_err = 0;

    cmd_vote_hub #(.NP(NP), .W(W), .WIN(8)) uut (
        .clk(clk), .rst_n(rst_n), .lane_data(lane_data), .lane_vld(lane_vld),
        .cfg_wr(cfg_wr), .cfg_steer(cfg_steer), .cfg_en(cfg_en),
        .cmd_vld(cmd_vld), .cmd_word(cmd_word), .cmd_disagree(cmd_disagree),
        .cmd_mismatch(cmd_mismatch), .cmd_timeout(cmd_timeout)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic chk_out(input string req, input logic ev, input logic [W-1:0] ew,
                           input logic ed, input logic em, input logic et);
        chk({req, " vld"}, cmd_vld, ev);
        if (ev) chk({req, " word"}, cmd_word, ew);
        chk({req, " disagree"}, cmd_disagree, ed);
        chk({req, " mismatch"}, cmd_mismatch, em);
        chk({req, " timeout"}, cmd_timeout, et);
    endtask

    // Called at a negedge; returns at the next negedge with outputs settled.
    task automatic set_cfg(input logic [NP*3-1:0] st, input logic [NP-1:0] en);
        cfg_steer = st; cfg_en = en; cfg_wr = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic fire(input logic [NL*W-1:0] d, input logic [NL-1:0] v);
        lane_data = d; lane_vld = v;
        @(negedge clk);
        lane_vld = '0;
    endtask

    function automatic logic [NL*W-1:0] rep(input logic [W-1:0] w);
        logic [NL*W-1:0] r;
        for (int k = 0; k < NL; k++) r[k*W +: W] = w;
        return r;
    endfunction

    // Reference: steering, strict majority, two-slot conflict.
    task automatic model(input logic [NL*W-1:0] d, input logic [NP*3-1:0] st,
                         input logic [NP-1:0] en, output logic ev, output logic [W-1:0] ew,
                         output logic ed, output logic em);
        logic [W-1:0] sw [NP];
        int ne = 0;
        logic diff = 1'b0;
        for (int s = 0; s < NP; s++) begin
            logic [2:0] f = st[s*3 +: 3];
            int idx = (f >= 3'd4) ? NP + int'(f) - 4 : s;
            sw[s] = d[idx*W +: W];
            if (en[s]) ne++;
        end
        for (int b = 0; b < W; b++) begin
            int c = 0;
            for (int s = 0; s < NP; s++) if (en[s] && sw[s][b]) c++;
            ew[b] = (2*c > ne);
        end
        for (int s = 0; s < NP; s++) if (en[s] && sw[s] != ew) diff = 1'b1;
        ev = 1'b0; ed = 1'b0; em = 1'b0;
        if (ne == 2 && diff) em = 1'b1;
        else if (ne > 0) begin ev = 1'b1; ed = diff; end
    endtask

    initial begin
        #(CLK_P * 150000);
        n_chk++; n_err++;
        $display("FAIL watchdog R8 act=running exp=finished");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        logic [NL*W-1:0] d;
        logic ev, ed, em;
        logic [W-1:0] ew;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        chk_out("R1 in reset", 0, 0, 0, 0, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk_out("R1 after reset", 0, 0, 0, 0, 0);

        // R1 defaults: own lanes, all enabled; spare data must not matter.
        d = rep(8'h5A);
        for (int k = NP; k < NL; k++) d[k*W +: W] = 8'hA5;
        fire(d, 12'h0FF);
        chk_out("R1 default cfg", 1, 8'h5A, 0, 0, 0);

        // R4/R6 majority with dissent.
        d = rep(8'h0F);
        for (int k = 5; k < 8; k++) d[k*W +: W] = 8'hF0;
        fire(d, 12'h0FF);
        chk_out("R4 R6 five vs three", 1, 8'h0F, 1, 0, 0);
        fire(rep(8'h77), 12'h0FF);
        chk_out("R6 unanimous", 1, 8'h77, 0, 0, 0);

        // R4 tie gives zero.
        set_cfg('0, 8'h0F);
        d = rep(8'h00); d[0 +: W] = 8'hFF; d[W +: W] = 8'hFF;
        fire(d, 12'h00F);
        chk_out("R4 tie", 1, 8'h00, 1, 0, 0);

        // R2/R3: slot 3 from spare 1 (lane 9), slot 5 with reserved code 2.
        set_cfg({3'd0, 3'd0, 3'd2, 3'd0, 3'd5, 3'd0, 3'd0, 3'd0}, 8'hFF);
        d = rep(8'h33); d[3*W +: W] = 8'h99;
        fire(d, 12'h008);
        chk_out("R3 own lane ignored", 0, 0, 0, 0, 0);
        fire(d, 12'h2F7);
        chk_out("R2 R3 spare routed", 1, 8'h33, 0, 0, 0);

        // R8/R10: one slot per cycle, slot 0 repeats, last arrives on 8th edge.
        set_cfg('0, 8'hFF);
        for (int k = 0; k < 8; k++) begin
            d = rep(8'h3C);
            if (k == 1) d[0 +: W] = 8'hC3;
            fire(d, (k == 1) ? 12'h003 : (12'h001 << k));
            if (k < 7) chk_out("R8 waiting", 0, 0, 0, 0, 0);
            else chk_out("R8 R10 eighth edge", 1, 8'h3C, 0, 0, 0);
        end

        // R9 timeout on the 8th edge, captures dropped.
        fire(rep(8'h11), 12'h07F);
        chk_out("R9 opened", 0, 0, 0, 0, 0);
        for (int k = 1; k < 8; k++) begin
            @(negedge clk);
            chk_out("R9 window", 0, 0, 0, 0, k == 7);
        end
        @(negedge clk);
        chk_out("R9 pulse ends", 0, 0, 0, 0, 0);
        fire(rep(8'h22), 12'h080);
        chk_out("R9 fresh window", 0, 0, 0, 0, 0);
        fire(rep(8'h22), 12'h07F);
        chk_out("R9 old words dropped", 1, 8'h22, 0, 0, 0);

        // R7 two-slot conflict and agreement.
        set_cfg('0, 8'h05);
        d = rep(8'h81); d[2*W +: W] = 8'h18;
        fire(d, 12'h005);
        chk_out("R7 conflict", 0, 0, 0, 1, 0);
        @(negedge clk);
        chk_out("R7 pulse ends", 0, 0, 0, 0, 0);
        fire(rep(8'h81), 12'h005);
        chk_out("R7 agree", 1, 8'h81, 0, 0, 0);

        // R11 single slot.
        set_cfg('0, 8'h10);
        d = rep(8'h00); d[4*W +: W] = 8'hB7;
        fire(d, 12'h010);
        chk_out("R11 single", 1, 8'hB7, 0, 0, 0);

        // R5 disabled slot neither opens nor votes.
        set_cfg('0, 8'h7F);
        fire(rep(8'hEE), 12'h080);
        chk_out("R5 no open", 0, 0, 0, 0, 0);
        for (int k = 0; k < 9; k++) @(negedge clk);
        chk_out("R5 no timeout", 0, 0, 0, 0, 0);
        d = rep(8'h44); d[7*W +: W] = 8'hEE;
        fire(d, 12'h0FF);
        chk_out("R5 excluded", 1, 8'h44, 0, 0, 0);

        // Random rounds: R2 R4 R6 R7 R12.
        for (int r = 0; r < 400; r++) begin
            logic [NP*3-1:0] st;
            logic [NP-1:0] en;
            logic [W-1:0] base;
            st = '0;
            for (int s = 0; s < NP; s++) st[s*3 +: 3] = 3'($urandom);
            en = NP'($urandom);
            base = W'($urandom);
            for (int k = 0; k < NL; k++)
                d[k*W +: W] = ($urandom % 4 == 0) ? W'($urandom) : base;
            set_cfg(st, en);
            fire(d, '1);
            model(d, st, en, ev, ew, ed, em);
            chk_out("R2 R4 R12 random", ev, ew, ed, em, 0);
        end

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule